// File: doc/BRIEF.md
# Outbound PCI Transaction Scheduler

This block sits behind a bridge's PCI master and decides, once the bridge owns the bus, which outbound transaction goes next. There are two candidates. One is the head of the outbound transaction queue, which arrives on a valid/ready descriptor port. The other is the head of an internal pending-read queue. The pending-read queue holds reads that were moved aside, rotated, or handed back by the master through a fill port. Each entry in that queue carries an address and a flag saying whether the read has already received some data.

The choice follows a fixed policy:
- A pending read that has already received data is issued first, and a competing new read is parked behind it.
- A pending read that has received nothing is rotated to the back, and the new read goes out.
- A write and a pending read take turns through a round-robin pointer.
- Once a write is issued, the block follows its burst. At each cache-line end the burst goes on into the next line only while no pending reads wait, and the burst ends at once when the latency timer expires.

Top module: `ob_txn_sched`

## Requirements
- R1: After reset no issue is presented, the pending-read queue is empty (fill_ready_o is 1), and wr_cont_o and wr_stop_o are 0.
- R2: With the pending-read queue empty, a valid outbound-queue descriptor is accepted (otq_ready_o=1 in that cycle). It is presented on the issue port in the next cycle with iss_from_rdq_o=0 and iss_got_o=0.
- R3: If the outbound head is a read (otq_write_i=0) and the pending head has its data flag set, the pending head is issued (iss_from_rdq_o=1, iss_got_o=1). The outbound read is accepted and appended to the pending tail with its flag clear.
- R4: In the R3 situation with the pending queue full, the outbound read is not accepted (otq_ready_o=0), and the pending head is still issued.
- R5: If the outbound head is a read and the pending head's data flag is clear, the pending head moves to the tail and the outbound read is issued.
- R6: An outbound write and a non-empty pending queue alternate by round-robin. After reset the write wins first, and the pointer moves only on such a contested issue.
- R7: With no valid outbound descriptor, a non-empty pending queue issues its head, whatever its data flag.
- R8: An issued write opens a burst, and no decision is taken until the burst ends. At a line end (line_end_i=1) with the pending queue empty and no timer expiry, wr_cont_o pulses in the next cycle and the burst goes on.
- R9: At a line end with at least one pending read, wr_stop_o pulses in the next cycle and the burst ends.
- R10: A timer expiry (mlt_expired_i=1) in any burst cycle makes wr_stop_o pulse in the next cycle and ends the burst.
- R11: At most one decision is taken per cycle, and only while bus_grant_i and mst_idle_i are both 1.
- R12: fill_ready_o is 1 only when the pending queue is not full and no internal push happens in that cycle. An accepted fill entry is appended to the tail with its own data flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_grant_i | input | 1 | Bridge currently holds the bus grant |
| mst_idle_i | input | 1 | PCI master model can take a new transaction |
| otq_valid_i | input | 1 | Outbound queue head descriptor valid |
| otq_write_i | input | 1 | Outbound head is a write (1) or a read (0) |
| otq_addr_i | input | ADDR_W | Outbound head address |
| otq_ready_o | output | 1 | Outbound head accepted this cycle |
| fill_valid_i | input | 1 | Master hands a read back to the pending queue |
| fill_addr_i | input | ADDR_W | Address of the handed-back read |
| fill_got_i | input | 1 | Handed-back read has received some data |
| fill_ready_o | output | 1 | Fill descriptor accepted this cycle |
| line_end_i | input | 1 | Write burst has reached a cache-line end |
| mlt_expired_i | input | 1 | Master latency timer has expired |
| iss_valid_o | output | 1 | Issue descriptor valid (one-cycle pulse) |
| iss_write_o | output | 1 | Issued transaction is a write |
| iss_addr_o | output | ADDR_W | Issued address |
| iss_from_rdq_o | output | 1 | Issued entry came from the pending-read queue |
| iss_got_o | output | 1 | Issued pending read had already received data |
| wr_cont_o | output | 1 | Write burst continues into the next line |
| wr_stop_o | output | 1 | Write burst ends |

## Verification
The two ready outputs are combinational and belong to the cycle whose inputs they answer. The bench therefore drives inputs on the falling edge and compares both ready outputs one time unit later. An issue decision appears on the issue port one rising edge later, and the burst pulses follow the same one-edge rule after a line end or a timer expiry. The behavioural queue model computes both of these expected values when the inputs are driven, and the bench compares them at the next falling edge. Counters of each policy branch confirm that every case from R2 to R10 was actually reached.

// File: rtl/obs_pkg.sv
package obs_pkg;

    typedef enum logic {
        SRC_OTQ = 1'b0,
        SRC_RDQ = 1'b1
    } iss_src_e;

    typedef enum logic {
        BST_IDLE = 1'b0,
        BST_RUN  = 1'b1
    } bst_state_e;

endpackage

// File: rtl/obs_rdq.sv
module obs_rdq #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              push_got_i,
    input  logic              pop_i,
    output logic [ADDR_W-1:0] head_addr_o,
    output logic              head_got_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0]             got;
        logic [PW-1:0]                rd;
        logic [PW-1:0]                wr;
        logic [CW-1:0]                cnt;
    } rdq_st_t;

    rdq_st_t st_d, st_q;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.addr[st_q.wr] = push_addr_i;
            st_d.got[st_q.wr]  = push_got_i;
            st_d.wr            = wrap_inc(st_q.wr);
        end
        if (pop_i) begin
            st_d.rd = wrap_inc(st_q.rd);
        end
        case ({push_i, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_addr_o = st_q.addr[st_q.rd];
    assign head_got_o  = st_q.got[st_q.rd];
    assign empty_o     = (st_q.cnt == '0);
    assign full_o      = (st_q.cnt == CW'(DEPTH));

    AST_RDQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |-> !full_o); // R12
    AST_RDQ_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R7

endmodule

// File: rtl/obs_rr.sv
module obs_rr (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output logic prefer_rd_o
);
    typedef struct packed {
        logic prefer_rd;
    } rr_st_t;

    rr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.prefer_rd = !st_q.prefer_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prefer_rd_o = st_q.prefer_rd;

    AST_RR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(prefer_rd_o)); // R6

endmodule

// File: rtl/obs_burst.sv
module obs_burst
    import obs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic line_end_i,
    input  logic mlt_i,
    input  logic rdq_busy_i,
    output logic active_o,
    output logic cont_o,
    output logic stop_o
);
    typedef struct packed {
        bst_state_e state;
        logic       cont;
        logic       stop;
    } bst_st_t;

    bst_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cont = 1'b0;
        st_d.stop = 1'b0;
        case (st_q.state)
            BST_IDLE: begin
                if (start_i) begin
                    st_d.state = BST_RUN;
                end
            end
            BST_RUN: begin
                if (mlt_i) begin
                    st_d.stop  = 1'b1;
                    st_d.state = BST_IDLE;
                end else if (line_end_i) begin
                    if (rdq_busy_i) begin
                        st_d.stop  = 1'b1;
                        st_d.state = BST_IDLE;
                    end else begin
                        st_d.cont = 1'b1;
                    end
                end
            end
            default: st_d.state = BST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: BST_IDLE, cont: 1'b0, stop: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.state == BST_RUN);
    assign cont_o   = st_q.cont;
    assign stop_o   = st_q.stop;

    AST_NO_START_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> !start_i); // R8
    AST_CONT_KEEPS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        cont_o |-> active_o); // R8
    AST_CONT_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cont_o |-> ($past(!rdq_busy_i) && $past(!mlt_i))); // R9
    AST_STOP_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !active_o); // R10

endmodule

// File: rtl/ob_txn_sched.sv
module ob_txn_sched
    import obs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned RDQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_grant_i,
    input  logic              mst_idle_i,
    input  logic              otq_valid_i,
    input  logic              otq_write_i,
    input  logic [ADDR_W-1:0] otq_addr_i,
    output logic              otq_ready_o,
    input  logic              fill_valid_i,
    input  logic [ADDR_W-1:0] fill_addr_i,
    input  logic              fill_got_i,
    output logic              fill_ready_o,
    input  logic              line_end_i,
    input  logic              mlt_expired_i,
    output logic              iss_valid_o,
    output logic              iss_write_o,
    output logic [ADDR_W-1:0] iss_addr_o,
    output logic              iss_from_rdq_o,
    output logic              iss_got_o,
    output logic              wr_cont_o,
    output logic              wr_stop_o
);
    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        iss_src_e          src;
        logic              got;
    } iss_st_t;

    iss_st_t iss_d, iss_q;

    logic              rdq_push, rdq_pop, rdq_empty, rdq_full;
    logic [ADDR_W-1:0] rdq_push_addr, rdq_head_addr;
    logic              rdq_push_got, rdq_head_got;
    logic              int_push, int_got;
    logic [ADDR_W-1:0] int_addr;
    logic              otq_rdy, fill_rdy;
    logic              can_dec, rd_avail, take_otq, take_rdq;
    logic              rr_adv, prefer_rd;
    logic              burst_start, burst_active;

    // Selection policy
    always_comb begin
        iss_d       = iss_q;
        iss_d.valid = 1'b0;
        take_otq    = 1'b0;
        take_rdq    = 1'b0;
        otq_rdy     = 1'b0;
        int_push    = 1'b0;
        int_addr    = otq_addr_i;
        int_got     = 1'b0;
        rr_adv      = 1'b0;
        can_dec     = bus_grant_i && mst_idle_i && !burst_active;
        rd_avail    = !rdq_empty;

        if (can_dec) begin
            if (otq_valid_i && !rd_avail) begin
                take_otq = 1'b1;
            end else if (otq_valid_i && otq_write_i) begin
                rr_adv = 1'b1;
                if (prefer_rd) begin
                    take_rdq = 1'b1;
                end else begin
                    take_otq = 1'b1;
                end
            end else if (otq_valid_i) begin
                if (rdq_head_got) begin
                    take_rdq = 1'b1;
                    if (!rdq_full) begin
                        otq_rdy  = 1'b1;
                        int_push = 1'b1;
                        int_addr = otq_addr_i;
                        int_got  = 1'b0;
                    end
                end else begin
                    take_otq = 1'b1;
                    int_push = 1'b1;
                    int_addr = rdq_head_addr;
                    int_got  = rdq_head_got;
                end
            end else if (rd_avail) begin
                take_rdq = 1'b1;
            end
        end

        if (take_otq) begin
            otq_rdy     = 1'b1;
            iss_d.valid = 1'b1;
            iss_d.write = otq_write_i;
            iss_d.addr  = otq_addr_i;
            iss_d.src   = SRC_OTQ;
            iss_d.got   = 1'b0;
        end else if (take_rdq) begin
            iss_d.valid = 1'b1;
            iss_d.write = 1'b0;
            iss_d.addr  = rdq_head_addr;
            iss_d.src   = SRC_RDQ;
            iss_d.got   = rdq_head_got;
        end
    end

    // Pending-queue write port: internal moves first, then the fill port
    always_comb begin
        rdq_pop       = take_rdq || (take_otq && int_push);
        fill_rdy      = !rdq_full && !int_push;
        rdq_push      = int_push || (fill_valid_i && fill_rdy);
        rdq_push_addr = int_push ? int_addr : fill_addr_i;
        rdq_push_got  = int_push ? int_got : fill_got_i;
        burst_start   = take_otq && otq_write_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_q <= '{valid: 1'b0, write: 1'b0, addr: '0, src: SRC_OTQ, got: 1'b0};
        end else begin
            iss_q <= iss_d;
        end
    end

    obs_rdq #(
        .ADDR_W (ADDR_W),
        .DEPTH  (RDQ_DEPTH)
    ) u_rdq (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (rdq_push),
        .push_addr_i (rdq_push_addr),
        .push_got_i  (rdq_push_got),
        .pop_i       (rdq_pop),
        .head_addr_o (rdq_head_addr),
        .head_got_o  (rdq_head_got),
        .empty_o     (rdq_empty),
        .full_o      (rdq_full)
    );

    obs_rr u_rr (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (rr_adv),
        .prefer_rd_o (prefer_rd)
    );

    obs_burst u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (burst_start),
        .line_end_i (line_end_i),
        .mlt_i      (mlt_expired_i),
        .rdq_busy_i (!rdq_empty),
        .active_o   (burst_active),
        .cont_o     (wr_cont_o),
        .stop_o     (wr_stop_o)
    );

    assign otq_ready_o    = otq_rdy;
    assign fill_ready_o   = fill_rdy;
    assign iss_valid_o    = iss_q.valid;
    assign iss_write_o    = iss_q.write;
    assign iss_addr_o     = iss_q.addr;
    assign iss_from_rdq_o = (iss_q.src == SRC_RDQ);
    assign iss_got_o      = iss_q.got;

    AST_ISSUE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid_o |-> $past(bus_grant_i && mst_idle_i)); // R11
    AST_OTQ_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        otq_ready_o |-> otq_valid_i); // R2
    AST_WRITE_OPENS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid_o && iss_write_o) |-> burst_active); // R8
    AST_NO_DECISION_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        burst_active |-> (!otq_ready_o && !rdq_pop)); // R8
    AST_FULL_STALLS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (otq_ready_o && !otq_write_i && !rdq_empty && rdq_head_got) |-> !rdq_full); // R4

endmodule

// File: tb/sim_ob_txn_sched.sv
module sim_ob_txn_sched;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;
    localparam int DEPTH      = 4;
    localparam int NCYC       = 4000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_grant_i, mst_idle_i;
    logic          otq_valid_i, otq_write_i;
    logic [AW-1:0] otq_addr_i;
    logic          otq_ready_o;
    logic          fill_valid_i, fill_got_i;
    logic [AW-1:0] fill_addr_i;
    logic          fill_ready_o;
    logic          line_end_i, mlt_expired_i;
    logic          iss_valid_o, iss_write_o, iss_from_rdq_o, iss_got_o;
    logic [AW-1:0] iss_addr_o;
    logic          wr_cont_o, wr_stop_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ob_txn_sched #(.ADDR_W(AW), .RDQ_DEPTH(DEPTH)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_grant_i    (bus_grant_i),
        .mst_idle_i     (mst_idle_i),
        .otq_valid_i    (otq_valid_i),
        .otq_write_i    (otq_write_i),
        .otq_addr_i     (otq_addr_i),
        .otq_ready_o    (otq_ready_o),
        .fill_valid_i   (fill_valid_i),
        .fill_addr_i    (fill_addr_i),
        .fill_got_i     (fill_got_i),
        .fill_ready_o   (fill_ready_o),
        .line_end_i     (line_end_i),
        .mlt_expired_i  (mlt_expired_i),
        .iss_valid_o    (iss_valid_o),
        .iss_write_o    (iss_write_o),
        .iss_addr_o     (iss_addr_o),
        .iss_from_rdq_o (iss_from_rdq_o),
        .iss_got_o      (iss_got_o),
        .wr_cont_o      (wr_cont_o),
        .wr_stop_o      (wr_stop_o)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // reference model state: bit AW of an entry is the data flag
    logic [AW:0] rq[$];
    bit          m_prefer_rd;
    bit          m_burst;
    bit          e_iv, e_iw, e_isrc, e_igot, e_cont, e_stop;
    logic [AW-1:0] e_ia;
    string       e_tag, e_btag;
    int n_r2, n_r3, n_r4, n_r5, n_r6w, n_r6r, n_r7, n_r8, n_r9, n_r10, n_r11;
    int otq_seq = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // one model step from current inputs; returns expected ready values
    task automatic model_step(output bit x_otq_rdy, output bit x_fill_rdy);
        bit dec, avail, full, busy0, ipush, t_otq, t_rdq;
        logic [AW:0] hd, pe;
        x_otq_rdy = 1'b0;
        ipush = 1'b0; t_otq = 1'b0; t_rdq = 1'b0;
        pe = '0;
        hd = (rq.size() > 0) ? rq[0] : '0;
        avail = (rq.size() > 0);
        full  = (rq.size() == DEPTH);
        busy0 = avail;
        dec = bus_grant_i && mst_idle_i && !m_burst;
        e_tag = "R11";
        if (dec) begin
            if (otq_valid_i && !avail) begin
                t_otq = 1'b1; e_tag = "R2"; n_r2++;
            end else if (otq_valid_i && otq_write_i) begin
                if (m_prefer_rd) begin t_rdq = 1'b1; n_r6r++; end
                else begin t_otq = 1'b1; n_r6w++; end
                m_prefer_rd = !m_prefer_rd;
                e_tag = "R6";
            end else if (otq_valid_i) begin
                if (hd[AW]) begin
                    t_rdq = 1'b1;
                    if (!full) begin
                        x_otq_rdy = 1'b1; ipush = 1'b1; pe = {1'b0, otq_addr_i};
                        e_tag = "R3"; n_r3++;
                    end else begin
                        e_tag = "R4"; n_r4++;
                    end
                end else begin
                    t_otq = 1'b1; ipush = 1'b1; pe = hd;
                    e_tag = "R5"; n_r5++;
                end
            end else if (avail) begin
                t_rdq = 1'b1; e_tag = "R7"; n_r7++;
            end
        end
        e_iv = 1'b0; e_iw = 1'b0; e_isrc = 1'b0; e_igot = 1'b0;
        if (t_otq) begin
            x_otq_rdy = 1'b1;
            e_iv = 1'b1; e_iw = otq_write_i; e_ia = otq_addr_i; e_isrc = 1'b0; e_igot = 1'b0;
        end else if (t_rdq) begin
            e_iv = 1'b1; e_iw = 1'b0; e_ia = hd[AW-1:0]; e_isrc = 1'b1; e_igot = hd[AW];
        end
        // burst outcome uses the queue occupancy at the start of the cycle
        e_cont = 1'b0; e_stop = 1'b0; e_btag = "R8";
        if (m_burst) begin
            if (mlt_expired_i) begin
                e_stop = 1'b1; m_burst = 1'b0; e_btag = "R10"; n_r10++;
            end else if (line_end_i) begin
                if (busy0) begin e_stop = 1'b1; m_burst = 1'b0; e_btag = "R9"; n_r9++; end
                else begin e_cont = 1'b1; n_r8++; end
            end
        end else if (t_otq && otq_write_i) begin
            m_burst = 1'b1;
        end
        if (!dec) n_r11++;
        x_fill_rdy = !full && !ipush;
        if (t_rdq || (t_otq && ipush)) void'(rq.pop_front());
        if (ipush) rq.push_back(pe);
        else if (fill_valid_i && x_fill_rdy) rq.push_back({fill_got_i, fill_addr_i});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit x_or, x_fr, acc_otq, acc_fill;
        int pg, pidle, pfill, pgot, pwr, ple, pmlt, potq;
        rst_n = 1'b0;
        bus_grant_i = 0; mst_idle_i = 0; otq_valid_i = 0; otq_write_i = 0; otq_addr_i = '0;
        fill_valid_i = 0; fill_addr_i = '0; fill_got_i = 0; line_end_i = 0; mlt_expired_i = 0;
        m_prefer_rd = 0; m_burst = 0; e_iv = 0; e_cont = 0; e_stop = 0; e_tag = "R1"; e_btag = "R1";
        n_r2 = 0; n_r3 = 0; n_r4 = 0; n_r5 = 0; n_r6w = 0; n_r6r = 0; n_r7 = 0;
        n_r8 = 0; n_r9 = 0; n_r10 = 0; n_r11 = 0;
        acc_otq = 1'b1; acc_fill = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 iss_valid", 64'(iss_valid_o), 64'd0);
        chk("R1 fill_ready", 64'(fill_ready_o), 64'd1);
        chk("R1 wr_cont", 64'(wr_cont_o), 64'd0);
        chk("R1 wr_stop", 64'(wr_stop_o), 64'd0);

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            // phase-dependent stimulus probabilities (percent)
            case (cyc / 1000)
                0: begin pg = 80; pidle = 80; potq = 60; pwr = 40; pfill = 30; pgot = 50; ple = 30; pmlt = 5; end
                1: begin pg = 30; pidle = 70; potq = 70; pwr = 10; pfill = 80; pgot = 90; ple = 20; pmlt = 5; end
                2: begin pg = 90; pidle = 90; potq = 70; pwr = 80; pfill = 15; pgot = 50; ple = 40; pmlt = 10; end
                default: begin pg = 70; pidle = 80; potq = 80; pwr = 20; pfill = 50; pgot = 20; ple = 30; pmlt = 30; end
            endcase
            if (acc_otq || !otq_valid_i) begin
                otq_valid_i = ($urandom_range(99) < potq);
                otq_write_i = ($urandom_range(99) < pwr);
                otq_seq++;
                otq_addr_i  = AW'(32'h1000_0000 + otq_seq * 64);
            end
            if (acc_fill || !fill_valid_i) begin
                fill_valid_i = ($urandom_range(99) < pfill);
                fill_got_i   = ($urandom_range(99) < pgot);
                fill_addr_i  = AW'($urandom);
            end
            bus_grant_i   = ($urandom_range(99) < pg);
            mst_idle_i    = ($urandom_range(99) < pidle);
            line_end_i    = ($urandom_range(99) < ple);
            mlt_expired_i = ($urandom_range(99) < pmlt);
            #1;
            model_step(x_or, x_fr);
            chk({e_tag, " otq_ready"}, 64'(otq_ready_o), 64'(x_or));
            chk("R12 fill_ready", 64'(fill_ready_o), 64'(x_fr));
            acc_otq  = otq_valid_i && x_or;
            acc_fill = fill_valid_i && x_fr;
            @(negedge clk);
            chk({e_tag, " iss_valid"}, 64'(iss_valid_o), 64'(e_iv));
            if (e_iv) begin
                chk({e_tag, " iss_write"}, 64'(iss_write_o), 64'(e_iw));
                chk({e_tag, " iss_addr"}, 64'(iss_addr_o), 64'(e_ia));
                chk({e_tag, " iss_from_rdq"}, 64'(iss_from_rdq_o), 64'(e_isrc));
                chk({e_tag, " iss_got"}, 64'(iss_got_o), 64'(e_igot));
            end
            chk({e_btag, " wr_cont"}, 64'(wr_cont_o), 64'(e_cont));
            chk({e_btag, " wr_stop"}, 64'(wr_stop_o), 64'(e_stop));
        end

        // every policy branch must have been reached
        chk("R2 reached", 64'(n_r2 > 0), 64'd1);
        chk("R3 reached", 64'(n_r3 > 0), 64'd1);
        chk("R4 reached", 64'(n_r4 > 0), 64'd1);
        chk("R5 reached", 64'(n_r5 > 0), 64'd1);
        chk("R6 write wins", 64'(n_r6w > 0), 64'd1);
        chk("R6 read wins", 64'(n_r6r > 0), 64'd1);
        chk("R7 reached", 64'(n_r7 > 0), 64'd1);
        chk("R8 reached", 64'(n_r8 > 0), 64'd1);
        chk("R9 reached", 64'(n_r9 > 0), 64'd1);
        chk("R10 reached", 64'(n_r10 > 0), 64'd1);
        chk("R11 reached", 64'(n_r11 > 0), 64'd1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule